// File: doc/BRIEF.md
# Disciplined Second and Millisecond Pulse Generator

This block turns the once-per-second on-time marker coming out of a time-code decoder into three timing outputs. The first is a high-active second pulse of fixed length. The second is a low-active millisecond square wave. The third is a one-cycle strobe that tells a downstream serial time-string formatter to start sending. Internal cycle, millisecond and second-of-minute counters are pulled into phase by every marker that arrives while the decoder reports lock. Between markers, and after the decoder loses lock, the counters run on by themselves from the system clock. The block has no backup clock, so every output stays quiet after reset until the first marker is accepted.

Two configuration inputs control the strobe. One sets the cadence: every second, or only once per minute at the second whose second-of-minute count becomes zero. The other sets the policy: send whenever the time is valid, or send only while the block is locked. The decoder marks the top of each minute by raising `minute_mark_i` together with the marker.

The controller is a three-state machine. WAIT is the state after reset, where all outputs are quiet. LOCKED means the block is following accepted markers. HOLD means it is free-running after lock was lost. The transitions are: WAIT to LOCKED on an accepted marker (lock_acquire); LOCKED to HOLD when `sync_ok_i` goes low (lock_lost); HOLD to LOCKED on an accepted marker (lock_regained). HOLD never returns to WAIT.

Top module: `pps_khz_gen`

## Requirements
- R1: From reset until the first accepted marker, `pps_o` is 0, `khz_n_o` is 1 and `str_start_o` is 0, whatever the other inputs do.
- R2: A marker is accepted only when `mark_i` and `sync_ok_i` are both high in the same cycle. An accepted marker starts a new second on the following clock edge, so the counters are zero in the next cycle. A marker seen while `sync_ok_i` is low has no effect on the phase of any output.
- R3: `pps_o` is high for exactly PPS_MS*CLK_PER_MS cycles, starting with the first cycle of each second, and is low for the rest of that second.
- R4: `khz_n_o` is low for the first CLK_PER_MS/2 cycles of every millisecond and high for the remaining cycles, so it is active-low with a 50/50 duty cycle.
- R5: With no accepted marker, a new second starts every CLK_PER_MS*MS_PER_SEC cycles. This continues after `sync_ok_i` drops. A marker that lands exactly on a natural second boundary produces only one second start.
- R6: `str_start_o` is one cycle wide and only rises in the first cycle of a second, together with the rising edge of `pps_o`.
- R7: With `cfg_every_sec_i`=1 the strobe may fire at every second start. With `cfg_every_sec_i`=0 it fires only where the second-of-minute count becomes 0. That count is forced to 0 by an accepted marker carrying `minute_mark_i`=1, and otherwise steps modulo SEC_PER_MIN at each second start. No per-minute strobe occurs before the first minute mark is accepted.
- R8: With `cfg_always_i`=1 a strobe requires `time_valid_i`=1 in the cycle before it. With `cfg_always_i`=0 it requires `sync_ok_i`=1 while the block is LOCKED, or an accepted marker in that cycle.
- R9: The state moves from WAIT to LOCKED on an accepted marker, from LOCKED to HOLD when `sync_ok_i` is low, and from HOLD to LOCKED only on an accepted marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mark_i | input | 1 | One-cycle on-time marker from the decoder |
| minute_mark_i | input | 1 | Qualifies a marker as the start of a minute |
| sync_ok_i | input | 1 | Decoder lock status |
| time_valid_i | input | 1 | Valid time information is available |
| cfg_every_sec_i | input | 1 | 1: strobe every second, 0: strobe once per minute |
| cfg_always_i | input | 1 | 1: strobe whenever time is valid, 0: only while locked |
| pps_o | output | 1 | High-active second pulse |
| khz_n_o | output | 1 | Low-active millisecond square wave |
| str_start_o | output | 1 | One-cycle start strobe for the serial time string |

## Verification
The bench first shows that markers given while lock is absent leave the block quiet. It then checks the first lock. A design that counted a marker falling on a natural boundary as an extra second would emit a doubled strobe, and the scoreboard would report it as unexpected. An early marker must pull the phase in, and a marker during holdover must be ignored; a design that got either wrong would move later pulses and strobes away from the predicted cycles. In per-minute mode, strobes before any minute mark must be suppressed, and the count of seconds must survive plain markers. A design that lost either would strobe at the wrong second. The policy cases check that the strobe stops when valid time is withdrawn, and that it stays off in HOLD even after lock status returns, until a fresh marker arrives.

// File: rtl/pps_khz_pkg.sv
package pps_khz_pkg;

    typedef enum logic [1:0] {
        ST_WAIT   = 2'd0,
        ST_LOCKED = 2'd1,
        ST_HOLD   = 2'd2
    } sync_state_t;

endpackage

// File: rtl/pps_khz_timebase.sv
module pps_khz_timebase #(
    parameter int CLK_PER_MS  = 10000,
    parameter int MS_PER_SEC  = 1000,
    parameter int SEC_PER_MIN = 60,
    localparam int CYC_W = $clog2(CLK_PER_MS),
    localparam int MS_W  = $clog2(MS_PER_SEC),
    localparam int SEC_W = $clog2(SEC_PER_MIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             load_i,
    input  logic             minute_mark_i,
    output logic [CYC_W-1:0] cyc_cnt_o,
    output logic [MS_W-1:0]  ms_cnt_o,
    output logic [SEC_W-1:0] sec_cnt_o,
    output logic             tick_o,
    output logic             min_top_o
);

    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CLK_PER_MS - 1);
    localparam logic [MS_W-1:0]  MS_LAST  = MS_W'(MS_PER_SEC - 1);
    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_MIN - 1);

    logic             ms_end;
    logic             wrap;
    logic             min_known_q;
    logic [SEC_W-1:0] sec_nxt;

    assign ms_end = run_i && (cyc_cnt_o == CYC_LAST);
    assign wrap   = ms_end && (ms_cnt_o == MS_LAST);
    assign tick_o = load_i || wrap;

    always_comb begin
        if (load_i && minute_mark_i) begin
            sec_nxt = '0;
        end else if (sec_cnt_o == SEC_LAST) begin
            sec_nxt = '0;
        end else begin
            sec_nxt = sec_cnt_o + 1'b1;
        end
    end

    assign min_top_o = tick_o &&
                       ((load_i && minute_mark_i) || (min_known_q && sec_cnt_o == SEC_LAST));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_cnt_o   <= '0;
            ms_cnt_o    <= '0;
            sec_cnt_o   <= '0;
            min_known_q <= 1'b0;
        end else begin
            if (load_i) begin
                cyc_cnt_o <= '0;
                ms_cnt_o  <= '0;
            end else if (run_i) begin
                if (ms_end) begin
                    cyc_cnt_o <= '0;
                    ms_cnt_o  <= wrap ? '0 : ms_cnt_o + 1'b1;
                end else begin
                    cyc_cnt_o <= cyc_cnt_o + 1'b1;
                end
            end
            if (tick_o) begin
                sec_cnt_o <= sec_nxt;
            end
            if (load_i && minute_mark_i) begin
                min_known_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pps_khz_ctrl.sv
module pps_khz_ctrl
    import pps_khz_pkg::*;
#(
    parameter int CLK_PER_MS = 10000,
    parameter int MS_PER_SEC = 1000,
    parameter int PPS_MS     = 50,
    localparam int CYC_W = $clog2(CLK_PER_MS),
    localparam int MS_W  = $clog2(MS_PER_SEC),
    localparam int HALF  = CLK_PER_MS / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mark_i,
    input  logic             sync_ok_i,
    input  logic             time_valid_i,
    input  logic             cfg_every_sec_i,
    input  logic             cfg_always_i,
    input  logic             tick_i,
    input  logic             min_top_i,
    input  logic [CYC_W-1:0] cyc_cnt_i,
    input  logic [MS_W-1:0]  ms_cnt_i,
    output sync_state_t      state_o,
    output logic             run_o,
    output logic             load_o,
    output logic             pps_o,
    output logic             khz_n_o,
    output logic             str_start_o
);

    sync_state_t state_q, state_d;
    logic        accept;
    logic        gate_ok;
    logic        cadence_ok;
    logic        strobe_q;

    assign accept = mark_i && sync_ok_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT:   if (accept)     state_d = ST_LOCKED;
            ST_LOCKED: if (!sync_ok_i) state_d = ST_HOLD;
            ST_HOLD:   if (accept)     state_d = ST_LOCKED;
            default:                   state_d = ST_WAIT;
        endcase
    end

    always_comb begin
        cadence_ok = cfg_every_sec_i || min_top_i;
        if (cfg_always_i) begin
            gate_ok = time_valid_i;
        end else begin
            gate_ok = (state_q == ST_LOCKED && sync_ok_i) || accept;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_WAIT;
            strobe_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            strobe_q <= tick_i && gate_ok && cadence_ok;
        end
    end

    always_comb begin
        state_o     = state_q;
        load_o      = accept;
        run_o       = (state_q != ST_WAIT);
        str_start_o = strobe_q;
        if (state_q == ST_WAIT) begin
            pps_o   = 1'b0;
            khz_n_o = 1'b1;
        end else begin
            pps_o   = (ms_cnt_i < MS_W'(PPS_MS));
            khz_n_o = (cyc_cnt_i >= CYC_W'(HALF));
        end
    end

endmodule

// File: rtl/pps_khz_gen.sv
module pps_khz_gen
    import pps_khz_pkg::*;
#(
    parameter int CLK_PER_MS  = 10000,
    parameter int MS_PER_SEC  = 1000,
    parameter int PPS_MS      = 50,
    parameter int SEC_PER_MIN = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mark_i,
    input  logic minute_mark_i,
    input  logic sync_ok_i,
    input  logic time_valid_i,
    input  logic cfg_every_sec_i,
    input  logic cfg_always_i,
    output logic pps_o,
    output logic khz_n_o,
    output logic str_start_o
);

    localparam int CYC_W = $clog2(CLK_PER_MS);
    localparam int MS_W  = $clog2(MS_PER_SEC);
    localparam int SEC_W = $clog2(SEC_PER_MIN);

    sync_state_t      st;
    logic             run;
    logic             load;
    logic             tick;
    logic             min_top;
    logic [CYC_W-1:0] cyc_cnt;
    logic [MS_W-1:0]  ms_cnt;
    logic [SEC_W-1:0] sec_cnt;

    pps_khz_timebase #(
        .CLK_PER_MS (CLK_PER_MS),
        .MS_PER_SEC (MS_PER_SEC),
        .SEC_PER_MIN(SEC_PER_MIN)
    ) u_tb (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (run),
        .load_i       (load),
        .minute_mark_i(minute_mark_i),
        .cyc_cnt_o    (cyc_cnt),
        .ms_cnt_o     (ms_cnt),
        .sec_cnt_o    (sec_cnt),
        .tick_o       (tick),
        .min_top_o    (min_top)
    );

    pps_khz_ctrl #(
        .CLK_PER_MS(CLK_PER_MS),
        .MS_PER_SEC(MS_PER_SEC),
        .PPS_MS    (PPS_MS)
    ) u_ctl (
        .clk            (clk),
        .rst_n          (rst_n),
        .mark_i         (mark_i),
        .sync_ok_i      (sync_ok_i),
        .time_valid_i   (time_valid_i),
        .cfg_every_sec_i(cfg_every_sec_i),
        .cfg_always_i   (cfg_always_i),
        .tick_i         (tick),
        .min_top_i      (min_top),
        .cyc_cnt_i      (cyc_cnt),
        .ms_cnt_i       (ms_cnt),
        .state_o        (st),
        .run_o          (run),
        .load_o         (load),
        .pps_o          (pps_o),
        .khz_n_o        (khz_n_o),
        .str_start_o    (str_start_o)
    );

endmodule

// File: rtl/pps_khz_gen_chk.sv
module pps_khz_gen_chk
    import pps_khz_pkg::*;
#(
    parameter int CLK_PER_MS  = 10000,
    parameter int MS_PER_SEC  = 1000,
    parameter int PPS_MS      = 50,
    parameter int SEC_PER_MIN = 60,
    localparam int CYC_W   = $clog2(CLK_PER_MS),
    localparam int MS_W    = $clog2(MS_PER_SEC),
    localparam int SEC_W   = $clog2(SEC_PER_MIN),
    localparam int PPS_CYC = PPS_MS * CLK_PER_MS,
    localparam int HALF    = CLK_PER_MS / 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mark_i,
    input logic             sync_ok_i,
    input logic             time_valid_i,
    input logic             cfg_every_sec_i,
    input logic             cfg_always_i,
    input logic             pps_o,
    input logic             khz_n_o,
    input logic             str_start_o,
    input sync_state_t      st,
    input logic [CYC_W-1:0] cyc_cnt,
    input logic [MS_W-1:0]  ms_cnt,
    input logic [SEC_W-1:0] sec_cnt
);

    int hi_run;
    int lo_run;
    logic acc;

    assign acc = mark_i && sync_ok_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run <= 0;
            lo_run <= 0;
        end else begin
            hi_run <= (!pps_o || acc) ? 0 : hi_run + 1;
            lo_run <= (khz_n_o || acc) ? 0 : lo_run + 1;
        end
    end

    // R1
    p_quiet_before_lock_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT) |-> (!pps_o && khz_n_o && !str_start_o));

    // R2 and R9
    p_lock_on_mark_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_LOCKED && mark_i && sync_ok_i) |=> (st == ST_LOCKED && cyc_cnt == '0 && ms_cnt == '0));

    p_hold_on_loss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOCKED && !sync_ok_i) |=> (st == ST_HOLD));

    p_pps_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pps_o |-> (hi_run < PPS_CYC));

    p_khz_low_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !khz_n_o |-> (lo_run < HALF));

    p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        str_start_o |=> !str_start_o);

    p_strobe_at_second_r6: assert property (@(posedge clk) disable iff (!rst_n)
        str_start_o |-> (pps_o && cyc_cnt == '0 && ms_cnt == '0));

    p_minute_cadence_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (str_start_o && !$past(cfg_every_sec_i)) |-> (sec_cnt == '0));

    p_policy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        str_start_o |-> ($past(cfg_always_i) ? $past(time_valid_i) : $past(sync_ok_i)));

endmodule

bind pps_khz_gen pps_khz_gen_chk #(
    .CLK_PER_MS (CLK_PER_MS),
    .MS_PER_SEC (MS_PER_SEC),
    .PPS_MS     (PPS_MS),
    .SEC_PER_MIN(SEC_PER_MIN)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .mark_i         (mark_i),
    .sync_ok_i      (sync_ok_i),
    .time_valid_i   (time_valid_i),
    .cfg_every_sec_i(cfg_every_sec_i),
    .cfg_always_i   (cfg_always_i),
    .pps_o          (pps_o),
    .khz_n_o        (khz_n_o),
    .str_start_o    (str_start_o),
    .st             (st),
    .cyc_cnt        (cyc_cnt),
    .ms_cnt         (ms_cnt),
    .sec_cnt        (sec_cnt)
);

// File: tb/pps_khz_gen_tb.sv
`timescale 1ns/1ps
module pps_khz_gen_tb;

    localparam int CPM  = 4;
    localparam int MPS  = 10;
    localparam int PMS  = 3;
    localparam int SPM  = 6;
    localparam int SECC = CPM * MPS;
    localparam int PPSC = PMS * CPM;
    localparam int MINC = SECC * SPM;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mark_i = 1'b0;
    logic minute_mark_i = 1'b0;
    logic sync_ok_i = 1'b0;
    logic time_valid_i = 1'b0;
    logic cfg_every_sec_i = 1'b0;
    logic cfg_always_i = 1'b0;
    logic pps_o, khz_n_o, str_start_o;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int exp_q[$];
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pps_khz_gen #(
        .CLK_PER_MS (CPM),
        .MS_PER_SEC (MPS),
        .PPS_MS     (PMS),
        .SEC_PER_MIN(SPM)
    ) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .mark_i         (mark_i),
        .minute_mark_i  (minute_mark_i),
        .sync_ok_i      (sync_ok_i),
        .time_valid_i   (time_valid_i),
        .cfg_every_sec_i(cfg_every_sec_i),
        .cfg_always_i   (cfg_always_i),
        .pps_o          (pps_o),
        .khz_n_o        (khz_n_o),
        .str_start_o    (str_start_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, expv);
        end
    endtask

    // Scoreboard monitor: strobes are matched against expected cycles (R6, R7, R8)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (str_start_o) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7/R8 unexpected strobe", cyc, -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(e == cyc, "R6 strobe cycle", cyc, e);
                end
            end else if (exp_q.size() > 0 && exp_q[0] < cyc) begin
                int e;
                e = exp_q.pop_front();
                chk(1'b0, "R7/R8 missing strobe", 0, e);
            end
        end
    end

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Driver: marker pulse, accepted at the next edge; optionally predicts a strobe there
    task automatic drive_mark(input bit mm, input bit expect_str, output int k);
        k = cyc + 1;
        mark_i = 1'b1;
        minute_mark_i = mm;
        if (expect_str) exp_q.push_back(k);
        @(negedge clk);
        mark_i = 1'b0;
        minute_mark_i = 1'b0;
    endtask

    task automatic chk_pps(input int c, input bit v, input string req);
        wait_to(c);
        chk(pps_o == v, req, pps_o, v);
    endtask

    task automatic chk_khz(input int c, input bit v);
        wait_to(c);
        chk(khz_n_o == v, "R4 khz_n level", khz_n_o, v);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired at cycle %0d: actual 0 expected 1", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int k0, k1, k2, k3, k4, kx;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: quiet after reset even with valid time, lock flag and permissive config
        sync_ok_i = 1'b1; time_valid_i = 1'b1; cfg_always_i = 1'b1; cfg_every_sec_i = 1'b1;
        for (int i = 0; i < 4; i++) begin
            wait_to(cyc + 15);
            chk(pps_o == 1'b0 && khz_n_o == 1'b1 && str_start_o == 1'b0, "R1 quiet before lock",
                {pps_o, khz_n_o, str_start_o}, 3'b010);
        end
        // R2: marker without lock is ignored
        sync_ok_i = 1'b0;
        drive_mark(1'b0, 1'b0, kx);
        wait_to(kx + 5);
        chk(pps_o == 1'b0 && khz_n_o == 1'b1, "R2 marker ignored without lock", pps_o, 0);

        // First lock, per-second cadence, sync-only policy
        sync_ok_i = 1'b1; cfg_always_i = 1'b0;
        @(negedge clk);
        drive_mark(1'b0, 1'b1, k0);
        chk_pps(k0, 1'b1, "R3 pps rises at second start");
        chk_khz(k0, 1'b0);
        chk_khz(k0 + 1, 1'b0);
        chk_khz(k0 + 2, 1'b1);
        chk_khz(k0 + 3, 1'b1);
        chk_khz(k0 + 4, 1'b0);
        chk_pps(k0 + PPSC - 1, 1'b1, "R3 pps last high cycle");
        chk_pps(k0 + PPSC, 1'b0, "R3 pps falls");
        // R5: marker on natural boundary gives one second start
        wait_to(k0 + SECC - 1);
        drive_mark(1'b0, 1'b1, kx);
        chk(kx == k0 + SECC, "R5 coincident marker", kx, k0 + SECC);
        // R2: early marker pulls the phase in
        wait_to(k0 + 65);
        drive_mark(1'b0, 1'b1, k1);
        chk_pps(k1, 1'b1, "R2 resync pps high");
        chk_pps(k1 + PPSC, 1'b0, "R2 resync pps low");
        exp_q.push_back(k1 + SECC);

        // Holdover (R5, R9): lock lost, sync-only policy blocks strobes
        wait_to(k1 + 45);
        sync_ok_i = 1'b0;
        chk_pps(k1 + 2 * SECC - 1, 1'b0, "R5 holdover before boundary");
        chk_pps(k1 + 2 * SECC, 1'b1, "R5 holdover second start");
        wait_to(k1 + 90);
        drive_mark(1'b0, 1'b0, kx);     // R2: ignored while unlocked
        wait_to(k1 + 100);
        cfg_always_i = 1'b1; time_valid_i = 1'b1;
        exp_q.push_back(k1 + 3 * SECC); // R8 always policy, phase unchanged
        wait_to(k1 + 125);
        time_valid_i = 1'b0;            // R8: no strobe at k1+160
        chk_pps(k1 + 4 * SECC, 1'b1, "R5 holdover pps continues");
        wait_to(k1 + 165);
        time_valid_i = 1'b1;
        exp_q.push_back(k1 + 5 * SECC);
        wait_to(k1 + 205);
        cfg_always_i = 1'b0;            // R9: still HOLD, lock flag alone is not enough
        sync_ok_i = 1'b1;
        chk_pps(k1 + 6 * SECC, 1'b1, "R9 hold pps at boundary");
        wait_to(k1 + 249);
        drive_mark(1'b0, 1'b1, k2);

        // Per-minute cadence (R7): nothing before first minute mark
        wait_to(k2 + 5);
        cfg_every_sec_i = 1'b0;
        wait_to(k2 + 289);
        drive_mark(1'b1, 1'b1, k3);
        exp_q.push_back(k3 + MINC);
        for (int s = 1; s <= 2; s++) begin
            wait_to(k3 + s * SECC - 1);
            drive_mark(1'b0, 1'b0, kx); // plain markers keep the count
        end
        chk_pps(k3 + 3 * SECC, 1'b1, "R7 pps every second in minute mode");
        wait_to(k3 + MINC + 9);
        // R7: minute mark mid-minute restarts the count
        drive_mark(1'b1, 1'b1, k4);
        exp_q.push_back(k4 + MINC);
        wait_to(k4 + MINC + 5);
        chk(exp_q.size() == 0, "R7 all predicted strobes seen", exp_q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule